// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces word addresses for a synchronous burst memory. A burst begins when either of two start strobes is sampled high at a rising clock edge. One strobe comes from the processor side and counts only while chip enable is high. The other comes from the memory controller side and always counts. On a start, the external address is captured. The following three beats are then generated internally by a 2-bit beat counter, which moves only on edges where the advance input is high.

The low two address bits follow one of two orders, chosen by a mode input that is captured at the start of each burst:
- Linear order: the start offset plus the beat count, modulo four.
- Interleaved order: the start offset XORed with the beat count. A mode input held low selects this order, so it is the default.

The upper address bits stay fixed for the whole burst. A start may be issued on every cycle, and each one takes effect at the next edge with no idle cycle in between. A flag marks the first beat of each burst, and a status output shows whether a burst is in progress.

Top module: `burst_addr_seq`

## Requirements
- R1: One cycle after a clock edge with the synchronous reset high, wordAddr is 0, firstBeat is 0 and inBurst is 0.
- R2: An edge with ctrlStrobe high loads extAddr whatever chipEn is. After that edge, wordAddr equals the sampled extAddr and firstBeat and inBurst are both 1.
- R3: An edge with hostStrobe high and chipEn high loads extAddr in the same way as R2. An edge with hostStrobe high and chipEn low is ignored: the outputs stay as they would be without the strobe.
- R4: When both strobes are high in the same cycle, the processor-side strobe takes priority. The single address sampled on that edge is loaded exactly once.
- R5: During a burst, an edge with no start and advance low leaves wordAddr and firstBeat unchanged. An edge with no start and advance high increments the beat count modulo 4 and clears firstBeat.
- R6: With linearMode = 1 sampled at the start, wordAddr[1:0] equals (start[1:0] + beat count) mod 4.
- R7: With linearMode = 0 sampled at the start, wordAddr[1:0] equals start[1:0] XOR beat count.
- R8: wordAddr[ADDR_W-1:2] is unchanged by advancing. After four advances the address wraps back to the start address within its aligned group of four.
- R9: A start overrides advance on the same edge. Starts on consecutive edges each load their own address, with no lost cycle.
- R10: Outside a burst (inBurst = 0), advance has no effect.
- R11: The linearMode value sampled at the start governs the whole burst. Changing linearMode in the middle of a burst does not change the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| chipEn | input | 1 | Chip enable; qualifies hostStrobe only |
| hostStrobe | input | 1 | Processor-side burst start |
| ctrlStrobe | input | 1 | Controller-side burst start, not qualified |
| advance | input | 1 | Step to the next beat |
| linearMode | input | 1 | 1 = linear order, 0 = interleaved order; sampled at a start |
| extAddr | input | ADDR_W | External word address |
| wordAddr | output | ADDR_W | Current word address |
| firstBeat | output | 1 | High on the first beat of a burst |
| inBurst | output | 1 | A burst has been started since reset |

## Verification
Each internal register of this block has a visible effect on wordAddr, so a wrong internal state shows up at the ports one cycle after the edge that caused it:
- A corrupted beat counter or order flag shows in wordAddr[1:0] from the very next beat.
- A stale base address shows in the upper bits.
- A wrong active flag shows in inBurst, and in whether advance moves the address.

Rare faults, such as a wrong priority between the two strobes or a mode change leaking into a running burst, show only in the specific beat sequences that trigger them. Long random runs are therefore combined with directed wrap, hold and mode-change sequences.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;

  typedef struct packed {
    logic load;      // capture extAddr and mode, restart beat count
    logic step;      // advance beat count
    logic clear;     // synchronous reset of datapath
  } seqStrobes_t;

  function automatic logic [BEAT_W-1:0] orderLow(
    input logic [BEAT_W-1:0] startLow,
    input logic [BEAT_W-1:0] beat,
    input logic              isLinear
  );
    return isLinear ? BEAT_W'(startLow + beat) : (startLow ^ beat);
  endfunction
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        chipEn,
  input  logic        hostStrobe,
  input  logic        ctrlStrobe,
  input  logic        advance,
  output seqStrobes_t strb,
  output logic        inBurst,
  output logic        firstBeat
);
  logic hostStart;
  logic anyStart;
  logic activeQ;
  logic firstQ;

  // Processor-side strobe wins when both are present; it is qualified by chipEn.
  always_comb begin
    hostStart = hostStrobe & chipEn;
    anyStart  = hostStart | ctrlStrobe;
  end

  always_comb begin
    strb.clear = rst;
    strb.load  = ~rst & anyStart;
    strb.step  = ~rst & ~anyStart & activeQ & advance;
  end

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      activeQ <= 1'b0;
      firstQ  <= 1'b0;
    end else if (strb.load) begin
      activeQ <= 1'b1;
      firstQ  <= 1'b1;
    end else if (strb.step) begin
      firstQ  <= 1'b0;
    end
  end

  assign inBurst   = activeQ;
  assign firstBeat = firstQ;
endmodule

// File: rtl/burst_seq_datapath.sv
module burst_seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  seqStrobes_t       strb,
  input  logic              linearMode,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] wordAddr
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] baseQ;
  logic [BEAT_W-1:0] beatQ;
  logic              linQ;

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      baseQ <= '0;
      beatQ <= '0;
      linQ  <= 1'b0;
    end else if (strb.load) begin
      baseQ <= extAddr;
      beatQ <= '0;
      linQ  <= linearMode;
    end else if (strb.step) begin
      beatQ <= beatQ + 1'b1;
    end
  end

  generate
    if (UPPER_W > 0) begin : g_upper
      assign wordAddr[ADDR_W-1:BEAT_W] = baseQ[ADDR_W-1:BEAT_W];
    end
  endgenerate

  assign wordAddr[BEAT_W-1:0] = orderLow(baseQ[BEAT_W-1:0], beatQ, linQ);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chipEn,
  input  logic              hostStrobe,
  input  logic              ctrlStrobe,
  input  logic              advance,
  input  logic              linearMode,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] wordAddr,
  output logic              firstBeat,
  output logic              inBurst
);
  seqStrobes_t strb;

  burst_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .chipEn     (chipEn),
    .hostStrobe (hostStrobe),
    .ctrlStrobe (ctrlStrobe),
    .advance    (advance),
    .strb       (strb),
    .inBurst    (inBurst),
    .firstBeat  (firstBeat)
  );

  burst_seq_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .strb       (strb),
    .linearMode (linearMode),
    .extAddr    (extAddr),
    .wordAddr   (wordAddr)
  );
endmodule

// File: rtl/burst_addr_seq_checker.sv
module burst_addr_seq_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              chipEn,
  input logic              hostStrobe,
  input logic              ctrlStrobe,
  input logic              advance,
  input logic [ADDR_W-1:0] extAddr,
  input logic [ADDR_W-1:0] wordAddr,
  input logic              firstBeat,
  input logic              inBurst
);
  logic startIn;
  assign startIn = ctrlStrobe | (hostStrobe & chipEn);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (wordAddr == '0 && !firstBeat && !inBurst));

  a_r2_ctrl_load: assert property (@(posedge clk) disable iff (rst)
    ctrlStrobe |=> (wordAddr == $past(extAddr) && firstBeat && inBurst));

  a_r3_host_load: assert property (@(posedge clk) disable iff (rst)
    (hostStrobe && chipEn) |=> (wordAddr == $past(extAddr) && firstBeat && inBurst));

  a_r3_host_gated: assert property (@(posedge clk) disable iff (rst)
    (hostStrobe && !chipEn && !ctrlStrobe && !advance) |=>
      ($stable(wordAddr) && $stable(firstBeat) && $stable(inBurst)));

  a_r5_step_moves: assert property (@(posedge clk) disable iff (rst)
    (inBurst && advance && !startIn) |=>
      (wordAddr[1:0] != $past(wordAddr[1:0]) && !firstBeat));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!advance && !startIn) |=> ($stable(wordAddr) && $stable(firstBeat)));

  a_r8_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    !startIn |=> $stable(wordAddr[ADDR_W-1:2]));

  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    (!inBurst && !startIn) |=> (!inBurst && $stable(wordAddr)));
endmodule

bind burst_addr_seq burst_addr_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .chipEn     (chipEn),
  .hostStrobe (hostStrobe),
  .ctrlStrobe (ctrlStrobe),
  .advance    (advance),
  .extAddr    (extAddr),
  .wordAddr   (wordAddr),
  .firstBeat  (firstBeat),
  .inBurst    (inBurst)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          chipEn = 1'b0, hostStrobe = 1'b0, ctrlStrobe = 1'b0;
  logic          advance = 1'b0, linearMode = 1'b0;
  logic [AW-1:0] extAddr = '0;
  logic [AW-1:0] wordAddr;
  logic          firstBeat, inBurst;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // reference model state
  logic [AW-1:0] mBase = '0;
  logic [1:0]    mCnt  = '0;
  logic          mAct  = 1'b0, mFirst = 1'b0, mLin = 1'b0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
    .clk(clk), .rst(rst), .chipEn(chipEn), .hostStrobe(hostStrobe),
    .ctrlStrobe(ctrlStrobe), .advance(advance), .linearMode(linearMode),
    .extAddr(extAddr), .wordAddr(wordAddr), .firstBeat(firstBeat), .inBurst(inBurst)
  );

  function automatic logic [AW-1:0] expAddr();
    logic [1:0] low;
    low = mLin ? 2'(mBase[1:0] + mCnt) : (mBase[1:0] ^ mCnt);
    return {mBase[AW-1:2], low};
  endfunction

  task automatic check(input string tag);
    logic [AW-1:0] ea;
    ea = expAddr();
    total++;
    if (wordAddr !== ea || firstBeat !== mFirst || inBurst !== mAct) begin
      bad++;
      $display("FAIL %s: got addr=%h first=%b burst=%b, expected addr=%h first=%b burst=%b",
               tag, wordAddr, firstBeat, inBurst, ea, mFirst, mAct);
    end
  endtask

  // called at a negedge: drive, model the next edge, check at the next negedge
  task automatic cycle(input logic h, input logic c, input logic ce, input logic adv,
                       input logic lm, input logic [AW-1:0] a, input string tag);
    hostStrobe = h; ctrlStrobe = c; chipEn = ce; advance = adv;
    linearMode = lm; extAddr = a;
    if (c || (h && ce)) begin
      mBase = a; mCnt = '0; mAct = 1'b1; mFirst = 1'b1; mLin = lm;
    end else if (mAct && adv) begin
      mCnt = mCnt + 2'd1; mFirst = 1'b0;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic doReset();
    rst = 1'b1; hostStrobe = 0; ctrlStrobe = 0; advance = 0;
    mBase = '0; mCnt = '0; mAct = 0; mFirst = 0; mLin = 0;
    @(negedge clk);
    check("R1");
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    @(negedge clk);
    doReset();

    cycle(0, 0, 1, 1, 0, 20'h12345, "R10");       // advance with no burst
    cycle(1, 0, 0, 0, 0, 20'h0abcd, "R3");        // host strobe gated off
    cycle(0, 1, 0, 0, 1, 20'h0f3a1, "R2");        // ctrl loads with chipEn low, linear
    cycle(0, 0, 0, 1, 1, 20'h0, "R6");
    cycle(0, 0, 0, 0, 1, 20'h0, "R5");            // hold
    cycle(0, 0, 0, 1, 1, 20'h0, "R6");
    cycle(0, 0, 0, 1, 1, 20'h0, "R6");
    cycle(0, 0, 0, 1, 1, 20'h0, "R8");            // wrap back to start
    cycle(1, 0, 1, 0, 0, 20'h5a5a6, "R3");        // host load, interleaved, low=2
    cycle(0, 0, 1, 1, 1, 20'h0, "R11");           // mode toggled mid-burst
    cycle(0, 0, 1, 1, 0, 20'h0, "R7");
    cycle(0, 0, 1, 1, 1, 20'h0, "R11");
    cycle(1, 0, 0, 1, 0, 20'h11111, "R3");        // gated host, advance steps
    cycle(1, 1, 1, 1, 1, 20'h77773, "R4");        // both strobes
    cycle(0, 1, 0, 1, 0, 20'h22221, "R9");        // back-to-back, load beats advance
    cycle(1, 0, 1, 1, 1, 20'h33332, "R9");
    cycle(0, 0, 1, 1, 1, 20'h0, "R6");
    doReset();

    for (int i = 0; i < 4000; i++) begin
      logic h, c, ce, adv, lm;
      logic [AW-1:0] a;
      string tag;
      h   = ($urandom % 4) == 0;
      c   = ($urandom % 5) == 0;
      ce  = $urandom % 2;
      adv = ($urandom % 3) != 0;
      lm  = $urandom % 2;
      a   = AW'($urandom);
      if (h && c && ce)      tag = "R4";
      else if (c)            tag = "R2";
      else if (h)            tag = "R3";
      else if (!mAct)        tag = "R10";
      else if (!adv)         tag = "R5";
      else if (mLin)         tag = "R6";
      else                   tag = "R7";
      cycle(h, c, ce, adv, lm, a, tag);
      if ((i % 997) == 996) doReset();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule